// File: doc/BRIEF.md
# CAN Receive Message Queue

This block holds received CAN frames in a small ring of five message buffers. At any moment one buffer is the background buffer. Only the bit-level receiver writes to it, one byte at a time, while a frame is on the bus. The oldest stored message is in the foreground buffer. The CPU reads it through one fixed window of byte indices, so software always reads from the same place whichever physical buffer currently holds the message. Each buffer holds 15 bytes: control bits, a standard or extended identifier, up to eight data bytes and an optional time stamp. The byte layout belongs to the receiver and the software.

The receiver marks the end of each frame with a completion strobe. It also gives two qualifiers: whether the frame arrived without error, and whether the acceptance filter matched its identifier. The filter runs while the bytes are being written. The background buffer is committed to the queue only when both qualifiers are true. A fresh background buffer is then available at once, so a frame that starts right after the interframe space has somewhere to land. A frame that fails either qualifier leaves the queue unchanged, and the same background buffer is reused. A receive-full flag, optionally routed to an interrupt, tells software that the foreground holds a message. Software reads the message and then acknowledges the flag. The next queued message then moves to the foreground.

Top module: `can_rx_msg_fifo`

## Requirements
- R1: After reset, rxf, rxf_irq and overrun are all 0 and no message is held.
- R2: A message is stored only when rx_done is 1 while both rx_crc_ok and rx_id_match are 1. If the queue was empty, rxf is 1 from the first clock edge after that strobe.
- R3: A completion strobe with rx_crc_ok or rx_id_match at 0 stores nothing and leaves rxf unchanged. The background buffer is reused, so a later stored frame shows only its own bytes.
- R4: cpu_rd_data shows, without a clock delay, byte cpu_rd_idx of the oldest held message. Indices 15 and above read as 0.
- R5: Messages reach the foreground in the order they were stored.
- R6: cpu_ack_rxf while rxf is 1 removes the foreground message, and rxf is 0 in the following cycle. If more messages are held, rxf returns to 1 one cycle later and the foreground shows the next message.
- R7: cpu_ack_rxf while rxf is 0 has no effect on the held messages.
- R8: At most four messages are held. A qualifying frame that completes while four are held, with no acknowledge in the same cycle, is dropped and sets overrun. The held messages are unchanged.
- R9: overrun stays 1 until cpu_ack_ovr is pulsed. If a drop and cpu_ack_ovr occur in the same cycle, overrun ends up 1.
- R10: rxf_irq is 1 exactly when rxf is 1 and rxf_irq_en is 1.
- R11: Receiver byte writes (rx_wr_en, rx_wr_idx below 15) go only to the background buffer and never change the bytes of held messages.
- R12: If a qualifying frame completes in the same cycle as an accepted acknowledge while four messages are held, the frame is stored and overrun is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_wr_en | input | 1 | Receiver byte write strobe into the background buffer |
| rx_wr_idx | input | IDX_W (4) | Byte index of the receiver write |
| rx_wr_data | input | DW (8) | Byte written by the receiver |
| rx_done | input | 1 | Frame completion strobe, one cycle |
| rx_crc_ok | input | 1 | Frame ended without error (valid with rx_done) |
| rx_id_match | input | 1 | Acceptance filter matched (valid with rx_done) |
| cpu_rd_idx | input | IDX_W (4) | CPU byte index into the foreground window |
| cpu_rd_data | output | DW (8) | Foreground byte at cpu_rd_idx |
| cpu_ack_rxf | input | 1 | CPU acknowledge that releases the foreground |
| cpu_ack_ovr | input | 1 | CPU clear of the overrun flag |
| rxf_irq_en | input | 1 | Receive interrupt enable |
| rxf | output | 1 | Receive-full flag |
| rxf_irq | output | 1 | Receive interrupt request |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A wrong head pointer or message count appears at once in cpu_rd_data: the foreground window shows bytes from the wrong frame or stale bytes. The reference model compares that window, the flag and the interrupt on every cycle. A count that is off by one also shows up within one cycle of a commit as a wrong rxf or overrun level. A background pointer that drifts shows up when the next committed frame surfaces with bytes that do not match what the receiver wrote, or when a held message's bytes change.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;

    // Outcome of a frame completion strobe
    typedef enum logic [1:0] {
        EV_IDLE   = 2'd0,
        EV_STORE  = 2'd1,
        EV_DROP   = 2'd2,
        EV_REJECT = 2'd3
    } rx_evt_e;

    // A frame is worth keeping only if error-free and filter-accepted
    function automatic logic frame_kept(input logic crc_ok, input logic id_hit);
        return crc_ok & id_hit;
    endfunction

endpackage

// File: rtl/can_rxq_judge.sv
module can_rxq_judge
    import can_rxq_pkg::*;
(
    input  logic    done,
    input  logic    crc_ok,
    input  logic    id_hit,
    input  logic    no_room,
    output rx_evt_e evt
);

    always_comb begin
        evt = EV_IDLE;
        if (done) begin
            if (!frame_kept(crc_ok, id_hit)) begin
                evt = EV_REJECT;
            end else if (no_room) begin
                evt = EV_DROP;
            end else begin
                evt = EV_STORE;
            end
        end
    end

endmodule

// File: rtl/can_rxq_ctrl.sv
module can_rxq_ctrl
    import can_rxq_pkg::*;
#(
    parameter  int NUM_BUF = 5,
    localparam int PTR_W   = $clog2(NUM_BUF),
    localparam int CNT_W   = $clog2(NUM_BUF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic             crc_ok,
    input  logic             id_hit,
    input  logic             ack_rxf,
    input  logic             ack_ovr,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] bg_buf,
    output logic [CNT_W-1:0] occ,
    output logic             rxf,
    output logic             ovr
);

    // One buffer always stays free as the background buffer
    localparam int CAP = NUM_BUF - 1;

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [CNT_W-1:0] cnt;
        logic             rxf;
        logic             ovr;
    } ctrl_st_t;

    ctrl_st_t        st_d, st_q;
    logic            pop;
    logic [CNT_W-1:0] cnt_after_pop;
    logic            no_room;
    rx_evt_e         evt;
    logic [PTR_W:0]  ring_sum;

    can_rxq_judge u_judge (
        .done    (done),
        .crc_ok  (crc_ok),
        .id_hit  (id_hit),
        .no_room (no_room),
        .evt     (evt)
    );

    always_comb begin
        st_d          = st_q;
        pop           = ack_rxf & st_q.rxf;
        cnt_after_pop = st_q.cnt - CNT_W'(pop);
        no_room       = (cnt_after_pop == CNT_W'(CAP));

        if (pop) begin
            st_d.head = (st_q.head == PTR_W'(NUM_BUF - 1)) ? '0 : st_q.head + PTR_W'(1);
        end

        st_d.cnt = cnt_after_pop + CNT_W'(evt == EV_STORE);

        if (ack_ovr) begin
            st_d.ovr = 1'b0;
        end
        if (evt == EV_DROP) begin
            st_d.ovr = 1'b1;
        end

        // Flag drops for one cycle after a release, then reflects the queue
        st_d.rxf = pop ? 1'b0 : (st_d.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Background sits just past the newest held message, modulo the ring
    always_comb begin
        ring_sum = {1'b0, st_q.head} + {1'b0, PTR_W'(st_q.cnt)};
        if (int'(ring_sum) >= NUM_BUF) begin
            bg_buf = PTR_W'(ring_sum - (PTR_W + 1)'(NUM_BUF));
        end else begin
            bg_buf = PTR_W'(ring_sum);
        end
    end

    assign head = st_q.head;
    assign occ  = st_q.cnt;
    assign rxf  = st_q.rxf;
    assign ovr  = st_q.ovr;

endmodule

// File: rtl/can_rxq_store.sv
module can_rxq_store #(
    parameter  int NUM_BUF   = 5,
    parameter  int BUF_BYTES = 15,
    parameter  int DW        = 8,
    localparam int PTR_W     = $clog2(NUM_BUF),
    localparam int IDX_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_buf,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [PTR_W-1:0] rd_buf,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);

    logic [NUM_BUF-1:0][BUF_BYTES-1:0][DW-1:0] slots;
    logic                                      wr_in_range;

    assign wr_in_range = wr_en && (int'(wr_idx) < BUF_BYTES);

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
        logic [BUF_BYTES-1:0][DW-1:0] bytes_d, bytes_q;

        always_comb begin
            bytes_d = bytes_q;
            if (wr_in_range && (int'(wr_buf) == g)) begin
                bytes_d[wr_idx] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bytes_q <= '0;
            end else begin
                bytes_q <= bytes_d;
            end
        end

        assign slots[g] = bytes_q;
    end

    always_comb begin
        rd_data = '0;
        if ((int'(rd_idx) < BUF_BYTES) && (int'(rd_buf) < NUM_BUF)) begin
            rd_data = slots[rd_buf][rd_idx];
        end
    end

endmodule

// File: rtl/can_rx_msg_fifo.sv
module can_rx_msg_fifo #(
    parameter  int NUM_BUF   = 5,
    parameter  int BUF_BYTES = 15,
    parameter  int DW        = 8,
    localparam int PTR_W     = $clog2(NUM_BUF),
    localparam int CNT_W     = $clog2(NUM_BUF),
    localparam int IDX_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_wr_en,
    input  logic [IDX_W-1:0] rx_wr_idx,
    input  logic [DW-1:0]    rx_wr_data,
    input  logic             rx_done,
    input  logic             rx_crc_ok,
    input  logic             rx_id_match,
    input  logic [IDX_W-1:0] cpu_rd_idx,
    output logic [DW-1:0]    cpu_rd_data,
    input  logic             cpu_ack_rxf,
    input  logic             cpu_ack_ovr,
    input  logic             rxf_irq_en,
    output logic             rxf,
    output logic             rxf_irq,
    output logic             overrun
);

    logic [PTR_W-1:0] head_buf;
    logic [PTR_W-1:0] bg_buf;
    logic [CNT_W-1:0] occ_cnt;

    can_rxq_ctrl #(
        .NUM_BUF (NUM_BUF)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (rx_done),
        .crc_ok  (rx_crc_ok),
        .id_hit  (rx_id_match),
        .ack_rxf (cpu_ack_rxf),
        .ack_ovr (cpu_ack_ovr),
        .head    (head_buf),
        .bg_buf  (bg_buf),
        .occ     (occ_cnt),
        .rxf     (rxf),
        .ovr     (overrun)
    );

    can_rxq_store #(
        .NUM_BUF   (NUM_BUF),
        .BUF_BYTES (BUF_BYTES),
        .DW        (DW)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rx_wr_en),
        .wr_buf  (bg_buf),
        .wr_idx  (rx_wr_idx),
        .wr_data (rx_wr_data),
        .rd_buf  (head_buf),
        .rd_idx  (cpu_rd_idx),
        .rd_data (cpu_rd_data)
    );

    assign rxf_irq = rxf & rxf_irq_en;

endmodule

// File: rtl/can_rxq_chk.sv
module can_rxq_chk #(
    parameter  int NUM_BUF = 5,
    localparam int CNT_W   = $clog2(NUM_BUF),
    localparam int CAP     = NUM_BUF - 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_done,
    input logic             rx_crc_ok,
    input logic             rx_id_match,
    input logic             cpu_ack_rxf,
    input logic             cpu_ack_ovr,
    input logic             rxf_irq_en,
    input logic             rxf,
    input logic             rxf_irq,
    input logic             overrun,
    input logic [CNT_W-1:0] occ
);

    logic kept, rel;
    assign kept = rx_done && rx_crc_ok && rx_id_match;
    assign rel  = cpu_ack_rxf && rxf;

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_irq |-> (rxf && rxf_irq_en)); // R10
    AST_IRQ_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (rxf && rxf_irq_en) |-> rxf_irq); // R10
    AST_FLAG_HAS_MESSAGE: assert property (@(posedge clk) disable iff (!rst_n)
        rxf |-> (occ != '0)); // R2
    AST_STORE_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (kept && !rel && (int'(occ) < CAP)) |=> (occ == CNT_W'($past(occ) + 1'b1))); // R2
    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !(rx_crc_ok && rx_id_match) && !rel) |=> $stable(occ)); // R3
    AST_RELEASE_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> !rxf); // R6
    AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack_rxf && !rxf && !rx_done) |=> $stable(occ)); // R7
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= CAP); // R8
    AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (kept && !rel && (int'(occ) == CAP)) |=> (overrun && (int'(occ) == CAP))); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !cpu_ack_ovr) |=> overrun); // R9
    AST_FULL_ACK_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (kept && rel && (int'(occ) == CAP)) |=> ((int'(occ) == CAP) && $stable(overrun))); // R12

endmodule

bind can_rx_msg_fifo can_rxq_chk #(
    .NUM_BUF (NUM_BUF)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_done     (rx_done),
    .rx_crc_ok   (rx_crc_ok),
    .rx_id_match (rx_id_match),
    .cpu_ack_rxf (cpu_ack_rxf),
    .cpu_ack_ovr (cpu_ack_ovr),
    .rxf_irq_en  (rxf_irq_en),
    .rxf         (rxf),
    .rxf_irq     (rxf_irq),
    .overrun     (overrun),
    .occ         (occ_cnt)
);

// File: tb/tb_can_rx_msg_fifo.sv
module tb_can_rx_msg_fifo;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_wr_en, rx_done, rx_crc_ok, rx_id_match;
    logic [3:0] rx_wr_idx, cpu_rd_idx;
    logic [7:0] rx_wr_data;
    logic [7:0] cpu_rd_data;
    logic       cpu_ack_rxf, cpu_ack_ovr, rxf_irq_en;
    logic       rxf, rxf_irq, overrun;

    int  n_chk = 0;
    int  n_err = 0;
    bit  finished = 0;
    int  cyc = 0;

    // Reference model state
    int  qd[$];
    int  bg[15];
    bit  ref_rxf, ref_ovr;

    can_rx_msg_fifo dut (
        .clk (clk), .rst_n (rst_n),
        .rx_wr_en (rx_wr_en), .rx_wr_idx (rx_wr_idx), .rx_wr_data (rx_wr_data),
        .rx_done (rx_done), .rx_crc_ok (rx_crc_ok), .rx_id_match (rx_id_match),
        .cpu_rd_idx (cpu_rd_idx), .cpu_rd_data (cpu_rd_data),
        .cpu_ack_rxf (cpu_ack_rxf), .cpu_ack_ovr (cpu_ack_ovr),
        .rxf_irq_en (rxf_irq_en), .rxf (rxf), .rxf_irq (rxf_irq), .overrun (overrun)
    );

    always #10 clk = ~clk; // 20 ns period, 50 MHz

    function automatic int fb(input int k, input int i);
        return (k * 37 + i * 11 + 3) % 256;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Reference model: advances on each edge from the inputs in force
    always @(posedge clk) begin
        if (!rst_n) begin
            qd.delete();
            for (int i = 0; i < 15; i++) bg[i] = -1;
            ref_rxf = 0;
            ref_ovr = 0;
        end else begin
            bit pop, drop;
            pop  = cpu_ack_rxf && ref_rxf;
            drop = 0;
            if (rx_wr_en && rx_wr_idx < 15) bg[rx_wr_idx] = rx_wr_data;
            if (pop) repeat (15) void'(qd.pop_front());
            if (rx_done && rx_crc_ok && rx_id_match) begin
                if (qd.size() / 15 == 4) drop = 1;
                else begin
                    for (int i = 0; i < 15; i++) qd.push_back(bg[i]);
                    for (int i = 0; i < 15; i++) bg[i] = -1;
                end
            end
            if (cpu_ack_ovr) ref_ovr = 0;
            if (drop) ref_ovr = 1;
            ref_rxf = pop ? 1'b0 : (qd.size() != 0);
        end
    end

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished) begin
            chk(rxf === ref_rxf, "R2 R6 rxf vs model", rxf, ref_rxf);
            chk(rxf_irq === (ref_rxf && rxf_irq_en), "R10 irq vs model", rxf_irq, ref_rxf && rxf_irq_en);
            chk(overrun === ref_ovr, "R9 overrun vs model", overrun, ref_ovr);
            if (qd.size() > 0) begin
                int exp;
                exp = (cpu_rd_idx < 15) ? qd[cpu_rd_idx] : 0;
                if (exp >= 0) chk(cpu_rd_data === 8'(exp), "R4 foreground byte vs model", cpu_rd_data, exp);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            summary();
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic peek(input int idx);
        cpu_rd_idx = 4'(idx);
        #1;
    endtask

    task automatic send_frame(input int k, input bit ok, input bit hit,
                              input bit ack_end, input bit ovr_clr_end);
        for (int i = 0; i < 15; i++) begin
            rx_wr_en = 1; rx_wr_idx = 4'(i); rx_wr_data = 8'(fb(k, i));
            tick();
        end
        rx_wr_en = 0;
        rx_done = 1; rx_crc_ok = ok; rx_id_match = hit;
        cpu_ack_rxf = ack_end; cpu_ack_ovr = ovr_clr_end;
        tick();
        rx_done = 0; rx_crc_ok = 0; rx_id_match = 0;
        cpu_ack_rxf = 0; cpu_ack_ovr = 0;
    endtask

    task automatic ack();
        cpu_ack_rxf = 1;
        tick();
        cpu_ack_rxf = 0;
    endtask

    task automatic drain_expect(input int k, input string tag);
        peek(0);
        chk(rxf === 1'b1, tag, rxf, 1);
        chk(cpu_rd_data === 8'(fb(k, 0)), tag, cpu_rd_data, fb(k, 0));
        peek(14);
        chk(cpu_rd_data === 8'(fb(k, 14)), tag, cpu_rd_data, fb(k, 14));
        ack();
        tick();
    endtask

    initial begin
        rst_n = 0; rx_wr_en = 0; rx_wr_idx = 0; rx_wr_data = 0;
        rx_done = 0; rx_crc_ok = 0; rx_id_match = 0;
        cpu_rd_idx = 0; cpu_ack_rxf = 0; cpu_ack_ovr = 0; rxf_irq_en = 1;
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R1: reset state
        chk(rxf === 1'b0, "R1 rxf after reset", rxf, 0);
        chk(rxf_irq === 1'b0, "R1 irq after reset", rxf_irq, 0);
        chk(overrun === 1'b0, "R1 overrun after reset", overrun, 0);

        // R3: filter miss and error frame are discarded
        send_frame(90, 1, 0, 0, 0);
        chk(rxf === 1'b0, "R3 filter miss discarded", rxf, 0);
        send_frame(91, 0, 1, 0, 0);
        chk(rxf === 1'b0, "R3 error frame discarded", rxf, 0);

        // R2: accepted frame sets the flag on the next edge
        send_frame(1, 1, 1, 0, 0);
        chk(rxf === 1'b1, "R2 flag after store", rxf, 1);
        for (int i = 0; i < 16; i++) begin
            peek(i);
            chk(cpu_rd_data === 8'((i < 15) ? fb(1, i) : 0), "R4 R3 foreground window", cpu_rd_data,
                (i < 15) ? fb(1, i) : 0);
        end

        // R10: interrupt masking
        rxf_irq_en = 0; #1;
        chk(rxf_irq === 1'b0, "R10 masked irq", rxf_irq, 0);
        rxf_irq_en = 1; #1;
        chk(rxf_irq === 1'b1, "R10 enabled irq", rxf_irq, 1);

        send_frame(2, 1, 1, 0, 0);
        send_frame(3, 1, 1, 0, 0);

        // R11: background writes leave held messages untouched
        for (int i = 0; i < 6; i++) begin
            rx_wr_en = 1; rx_wr_idx = 4'(i); rx_wr_data = 8'hAA;
            tick();
        end
        rx_wr_en = 0;
        peek(0);
        chk(cpu_rd_data === 8'(fb(1, 0)), "R11 foreground unchanged by writes", cpu_rd_data, fb(1, 0));

        // R6: release with more queued
        ack();
        chk(rxf === 1'b0, "R6 flag low after release", rxf, 0);
        tick();
        chk(rxf === 1'b1, "R6 flag back with next message", rxf, 1);
        peek(0);
        chk(cpu_rd_data === 8'(fb(2, 0)), "R5 R6 next message in order", cpu_rd_data, fb(2, 0));

        // R7: acknowledge while flag is low is ignored
        ack();
        ack();
        peek(0);
        chk(rxf === 1'b1, "R7 ignored ack keeps message", rxf, 1);
        chk(cpu_rd_data === 8'(fb(3, 0)), "R7 ignored ack keeps foreground", cpu_rd_data, fb(3, 0));

        // R8: capacity four, fifth dropped with overrun
        send_frame(4, 1, 1, 0, 0);
        send_frame(5, 1, 1, 0, 0);
        send_frame(6, 1, 1, 0, 0);
        chk(overrun === 1'b0, "R8 no overrun at four held", overrun, 0);
        send_frame(7, 1, 1, 0, 0);
        chk(overrun === 1'b1, "R8 overrun on drop", overrun, 1);
        drain_expect(3, "R5 R8 order after drop");
        drain_expect(4, "R5 R8 order after drop");
        drain_expect(5, "R5 R8 order after drop");
        drain_expect(6, "R5 R8 order after drop");
        chk(rxf === 1'b0, "R8 dropped frame absent", rxf, 0);

        // R9: sticky overrun and clear
        chk(overrun === 1'b1, "R9 overrun sticky", overrun, 1);
        cpu_ack_ovr = 1; tick(); cpu_ack_ovr = 0;
        chk(overrun === 1'b0, "R9 overrun cleared", overrun, 0);

        // R12: store with simultaneous release when full
        send_frame(8, 1, 1, 0, 0);
        send_frame(9, 1, 1, 0, 0);
        send_frame(10, 1, 1, 0, 0);
        send_frame(11, 1, 1, 0, 0);
        send_frame(12, 1, 1, 1, 0);
        chk(overrun === 1'b0, "R12 no overrun with release", overrun, 0);
        tick();
        drain_expect(9, "R12 order");
        drain_expect(10, "R12 order");
        drain_expect(11, "R12 order");
        drain_expect(12, "R12 frame stored");
        chk(rxf === 1'b0, "R12 queue empty", rxf, 0);

        // R9: drop wins over a same-cycle clear
        send_frame(13, 1, 1, 0, 0);
        send_frame(14, 1, 1, 0, 0);
        send_frame(15, 1, 1, 0, 0);
        send_frame(16, 1, 1, 0, 0);
        send_frame(17, 1, 1, 0, 1);
        chk(overrun === 1'b1, "R9 set wins over clear", overrun, 1);
        drain_expect(13, "R8 order");
        drain_expect(14, "R8 order");
        drain_expect(15, "R8 order");
        drain_expect(16, "R8 order");

        repeat (3) tick();
        summary();
    end

endmodule